// File: doc/BRIEF.md
# Pseudo-Two-Port Banked Memory Router

This block puts two independent command ports in front of an array of single-ported memory banks. Each port carries its own bank, row and column address and its own open-row, close-row, read and write commands. A read and a write can complete in the same cycle when they target two different banks. The bank being read drives a shared global read bus, and the bank being written takes its data from a shared global write bus. Concurrency comes from how the buses are routed, not from dual-ported cells.

Each bank has one local data line that it uses for both reads and writes. A per-bank crosspoint connects that line to the read bus or the write bus, according to the bank address and the command. Page-mode accesses are tracked per bank: a row must be opened before a read or write, and a row address must match the open row. Read data and all error flags are registered and appear one cycle after the command that caused them. Rows and columns per row are powers of two.

Top module: `pt_bank_router`

## Requirements
- R1: Each port applies at most one command per cycle, chosen by priority: open-row (`*_open`) first, then close-row (`*_close`), then read, then write. Lower-priority bits asserted in the same cycle are ignored.
- R2: A read on both ports in one cycle raises `err_proto` in the next cycle. No read is performed and `rvalid` stays low.
- R3: A write on both ports in one cycle raises `err_proto` in the next cycle, and the array is left unchanged.
- R4: A read on one port and a write on the other, to two different banks, both complete in the same cycle. The read returns the contents from before that cycle, and the write is stored.
- R5: Commands from both ports to the same bank in one cycle (when the cycle is not already an R2/R3 case) raise `err_bank` in the next cycle. Neither command is performed.
- R6: Read data appears on `rdata` with `rvalid` high exactly one cycle after an accepted read. `rvalid` is low in every other cycle.
- R7: A read or write to a bank with no open row, or whose row address differs from the open row, raises `err_page` in the next cycle. It leaves the array unchanged and produces no `rvalid`.
- R8: Open-row on an idle bank opens the given row. Open-row on an already open bank raises `err_open` and keeps the current row. Close-row closes the bank.
- R9: While one bank receives a read every cycle, writes to another bank may be issued every cycle, and `rvalid` stays high on every cycle without a stall.
- R10: After reset all banks are closed and `rvalid`, `rdata` and all error flags are low. `err_proto` and `err_bank` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| a_open | input | 1 | port A open-row command |
| a_close | input | 1 | port A close-row command |
| a_rd | input | 1 | port A read command |
| a_wr | input | 1 | port A write command |
| a_bank | input | BW | port A bank address |
| a_row | input | RW | port A row address |
| a_col | input | CW | port A column address |
| b_open | input | 1 | port B open-row command |
| b_close | input | 1 | port B close-row command |
| b_rd | input | 1 | port B read command |
| b_wr | input | 1 | port B write command |
| b_bank | input | BW | port B bank address |
| b_row | input | RW | port B row address |
| b_col | input | CW | port B column address |
| wdata | input | DW | global write bus |
| rdata | output | DW | global read bus |
| rvalid | output | 1 | read data strobe |
| err_proto | output | 1 | dual read or dual write |
| err_bank | output | 1 | both ports hit one bank |
| err_page | output | 1 | access without matching open row |
| err_open | output | 1 | open-row on an open bank |

## Verification
The bound checker examines every cycle for the following:
- a dual read or dual write is followed by `err_proto` with no read strobe;
- commands from both ports to one bank are followed by `err_bank`;
- `rvalid` never rises without a read command in the cycle before;
- `err_proto` and `err_bank` are never high together.

Some behaviours are visible only through data moving through the array, so only the bench scenarios can show them. These are the value a read returns, whether a rejected write left the array untouched, which row an open-row produced, and how command priority resolves within a port. The bench also covers a long run of page reads interleaved with writes to another bank.

// File: rtl/pt_bank_router.sv
module pt_bank_router #(
  parameter int NBANK = 4,
  parameter int NROW  = 8,
  parameter int NCOL  = 8,
  parameter int DW    = 8,
  localparam int BW   = $clog2(NBANK),
  localparam int RW   = $clog2(NROW),
  localparam int CW   = $clog2(NCOL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_open,
  input  logic          a_close,
  input  logic          a_rd,
  input  logic          a_wr,
  input  logic [BW-1:0] a_bank,
  input  logic [RW-1:0] a_row,
  input  logic [CW-1:0] a_col,
  input  logic          b_open,
  input  logic          b_close,
  input  logic          b_rd,
  input  logic          b_wr,
  input  logic [BW-1:0] b_bank,
  input  logic [RW-1:0] b_row,
  input  logic [CW-1:0] b_col,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          err_proto,
  output logic          err_bank,
  output logic          err_page,
  output logic          err_open
);
  localparam int WORDS = NROW * NCOL;

  // per-port command decode, one command per port per cycle
  logic a_any, a_op, a_cl, a_rc, a_wc;
  logic b_any, b_op, b_cl, b_rc, b_wc;
  assign a_any = a_open | a_close | a_rd | a_wr;
  assign a_op  = a_open;
  assign a_cl  = a_close & ~a_open;
  assign a_rc  = a_rd & ~a_open & ~a_close;
  assign a_wc  = a_wr & ~a_open & ~a_close & ~a_rd;
  assign b_any = b_open | b_close | b_rd | b_wr;
  assign b_op  = b_open;
  assign b_cl  = b_close & ~b_open;
  assign b_rc  = b_rd & ~b_open & ~b_close;
  assign b_wc  = b_wr & ~b_open & ~b_close & ~b_rd;

  logic proto, clash, a_go, b_go;
  assign proto = (a_rc & b_rc) | (a_wc & b_wc);
  assign clash = ~proto & a_any & b_any & (a_bank == b_bank);
  assign a_go  = a_any & ~proto & ~clash;
  assign b_go  = b_any & ~proto & ~clash;

  logic [NBANK-1:0] rd_do, page_bad, open_bad;
  logic [DW-1:0]    sa_bus [NBANK];

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic          hit_a, hit_b, op_i, cl_i, rd_i, wr_i, row_ok;
    logic [RW-1:0] row_i;
    logic [CW-1:0] col_i;
    logic          is_open;
    logic [RW-1:0] open_row;
    logic [DW-1:0] cells [WORDS];
    logic [DW-1:0] local_line;
    logic [DW-1:0] sa_q;

    assign hit_a  = a_go & (a_bank == BW'(i));
    assign hit_b  = b_go & (b_bank == BW'(i));
    assign op_i   = (hit_a & a_op) | (hit_b & b_op);
    assign cl_i   = (hit_a & a_cl) | (hit_b & b_cl);
    assign rd_i   = (hit_a & a_rc) | (hit_b & b_rc);
    assign wr_i   = (hit_a & a_wc) | (hit_b & b_wc);
    assign row_i  = hit_a ? a_row : b_row;
    assign col_i  = hit_a ? a_col : b_col;
    assign row_ok = is_open & (open_row == row_i);

    assign rd_do[i]    = rd_i & row_ok;
    assign page_bad[i] = (rd_i | wr_i) & ~row_ok;
    assign open_bad[i] = op_i & is_open;

    // crosspoint: the one local line carries either write-bus data or cell data
    assign local_line = (wr_i & row_ok) ? wdata : cells[{row_i, col_i}];

    always_ff @(posedge clk) begin
      if (wr_i & row_ok) cells[{row_i, col_i}] <= local_line;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        is_open  <= 1'b0;
        open_row <= '0;
        sa_q     <= '0;
      end else begin
        sa_q <= rd_do[i] ? local_line : '0;
        if (op_i & ~is_open) begin
          is_open  <= 1'b1;
          open_row <= row_i;
        end else if (cl_i) begin
          is_open <= 1'b0;
        end
      end
    end

    assign sa_bus[i] = sa_q;
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NBANK; k++) rdata = rdata | sa_bus[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid    <= 1'b0;
      err_proto <= 1'b0;
      err_bank  <= 1'b0;
      err_page  <= 1'b0;
      err_open  <= 1'b0;
    end else begin
      rvalid    <= |rd_do;
      err_proto <= proto;
      err_bank  <= clash;
      err_page  <= |page_bad;
      err_open  <= |open_bad;
    end
  end
endmodule

// File: rtl/pt_bank_router_chk.sv
module pt_bank_router_chk #(
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_open,
  input logic          a_close,
  input logic          a_rd,
  input logic          a_wr,
  input logic [BW-1:0] a_bank,
  input logic          b_open,
  input logic          b_close,
  input logic          b_rd,
  input logic          b_wr,
  input logic [BW-1:0] b_bank,
  input logic          rvalid,
  input logic          err_proto,
  input logic          err_bank
);
  logic a_any, b_any, a_r, b_r, a_w, b_w;
  assign a_any = a_open | a_close | a_rd | a_wr;
  assign b_any = b_open | b_close | b_rd | b_wr;
  assign a_r   = a_rd & ~a_open & ~a_close;
  assign b_r   = b_rd & ~b_open & ~b_close;
  assign a_w   = a_wr & ~a_open & ~a_close & ~a_rd;
  assign b_w   = b_wr & ~b_open & ~b_close & ~b_rd;

  a_r2_dual_read: assert property (@(posedge clk) disable iff (!rst_n)
    (a_r && b_r) |=> (err_proto && !rvalid));

  a_r3_dual_write: assert property (@(posedge clk) disable iff (!rst_n)
    (a_w && b_w) |=> err_proto);

  a_r5_same_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (a_any && b_any && a_bank == b_bank && !(a_r && b_r) && !(a_w && b_w))
      |=> (err_bank && !rvalid));

  a_r6_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_r || b_r) |=> !rvalid);

  a_r10_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_proto, err_bank}));
endmodule

bind pt_bank_router pt_bank_router_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_open(a_open), .a_close(a_close), .a_rd(a_rd), .a_wr(a_wr), .a_bank(a_bank),
  .b_open(b_open), .b_close(b_close), .b_rd(b_rd), .b_wr(b_wr), .b_bank(b_bank),
  .rvalid(rvalid), .err_proto(err_proto), .err_bank(err_bank)
);

// File: tb/pt_bank_router_test.sv
module pt_bank_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       a_open, a_close, a_rd, a_wr, b_open, b_close, b_rd, b_wr;
  logic [1:0] a_bank, b_bank;
  logic [2:0] a_row, a_col, b_row, b_col;
  logic [7:0] wdata, rdata;
  logic       rvalid, err_proto, err_bank, err_page, err_open;

  pt_bank_router uut (
    .clk(clk), .rst_n(rst_n),
    .a_open(a_open), .a_close(a_close), .a_rd(a_rd), .a_wr(a_wr),
    .a_bank(a_bank), .a_row(a_row), .a_col(a_col),
    .b_open(b_open), .b_close(b_close), .b_rd(b_rd), .b_wr(b_wr),
    .b_bank(b_bank), .b_row(b_row), .b_col(b_col),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
    .err_proto(err_proto), .err_bank(err_bank), .err_page(err_page), .err_open(err_open)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // command nibble: open=8, close=4, read=2, write=1
  task automatic drive(input logic [3:0] ca, input logic [1:0] ba, input logic [2:0] ra,
                       input logic [2:0] cola, input logic [3:0] cb, input logic [1:0] bb,
                       input logic [2:0] rb, input logic [2:0] colb, input logic [7:0] wd);
    {a_open, a_close, a_rd, a_wr} = ca;
    {b_open, b_close, b_rd, b_wr} = cb;
    a_bank = ba; a_row = ra; a_col = cola;
    b_bank = bb; b_row = rb; b_col = colb;
    wdata = wd;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // {acmd,abank,arow,acol, bcmd,bbank,brow,bcol, wdata, exp_rvalid, exp_rdata, exp_err{proto,bank,page,open}}
  localparam int NV = 21;
  localparam logic [44:0] VEC [NV] = '{
    {4'h8,2'd0,3'd2,3'd0, 4'h8,2'd1,3'd5,3'd0, 8'd0,  1'b0,8'd0,  4'b0000},
    {4'h1,2'd0,3'd2,3'd3, 4'h0,2'd0,3'd0,3'd0, 8'd11, 1'b0,8'd0,  4'b0000},
    {4'h2,2'd0,3'd2,3'd3, 4'h1,2'd1,3'd5,3'd1, 8'd22, 1'b1,8'd11, 4'b0000},
    {4'h1,2'd0,3'd2,3'd4, 4'h2,2'd1,3'd5,3'd1, 8'd33, 1'b1,8'd22, 4'b0000},
    {4'h2,2'd0,3'd2,3'd4, 4'h2,2'd1,3'd5,3'd1, 8'd0,  1'b0,8'd0,  4'b1000},
    {4'h1,2'd0,3'd2,3'd3, 4'h1,2'd1,3'd5,3'd1, 8'd44, 1'b0,8'd0,  4'b1000},
    {4'h2,2'd0,3'd2,3'd3, 4'h0,2'd0,3'd0,3'd0, 8'd0,  1'b1,8'd11, 4'b0000},
    {4'h2,2'd0,3'd2,3'd3, 4'h1,2'd0,3'd2,3'd3, 8'd55, 1'b0,8'd0,  4'b0100},
    {4'h2,2'd0,3'd2,3'd3, 4'h0,2'd0,3'd0,3'd0, 8'd0,  1'b1,8'd11, 4'b0000},
    {4'h2,2'd2,3'd0,3'd0, 4'h0,2'd0,3'd0,3'd0, 8'd0,  1'b0,8'd0,  4'b0010},
    {4'h2,2'd0,3'd3,3'd3, 4'h0,2'd0,3'd0,3'd0, 8'd0,  1'b0,8'd0,  4'b0010},
    {4'h1,2'd1,3'd4,3'd1, 4'h0,2'd0,3'd0,3'd0, 8'd66, 1'b0,8'd0,  4'b0010},
    {4'h0,2'd0,3'd0,3'd0, 4'h2,2'd1,3'd5,3'd1, 8'd0,  1'b1,8'd22, 4'b0000},
    {4'h8,2'd0,3'd1,3'd0, 4'h0,2'd0,3'd0,3'd0, 8'd0,  1'b0,8'd0,  4'b0001},
    {4'h2,2'd0,3'd2,3'd4, 4'h0,2'd0,3'd0,3'd0, 8'd0,  1'b1,8'd33, 4'b0000},
    {4'h4,2'd1,3'd0,3'd0, 4'h2,2'd0,3'd2,3'd3, 8'd0,  1'b1,8'd11, 4'b0000},
    {4'h0,2'd0,3'd0,3'd0, 4'h2,2'd1,3'd5,3'd1, 8'd0,  1'b0,8'd0,  4'b0010},
    {4'hA,2'd2,3'd6,3'd0, 4'h0,2'd0,3'd0,3'd0, 8'd0,  1'b0,8'd0,  4'b0000},
    {4'h1,2'd2,3'd6,3'd7, 4'h0,2'd0,3'd0,3'd0, 8'd77, 1'b0,8'd0,  4'b0000},
    {4'h3,2'd2,3'd6,3'd7, 4'h0,2'd0,3'd0,3'd0, 8'd88, 1'b1,8'd77, 4'b0000},
    {4'h2,2'd2,3'd6,3'd7, 4'h0,2'd0,3'd0,3'd0, 8'd0,  1'b1,8'd77, 4'b0000}
  };

  initial begin
    drive(4'h0, 2'd0, 3'd0, 3'd0, 4'h0, 2'd0, 3'd0, 3'd0, 8'd0);
    repeat (3) @(negedge clk);
    // R10: state held in reset
    check({rvalid, rdata, err_proto, err_bank, err_page, err_open} == '0, "R10 reset outputs",
          int'({rvalid, rdata, err_proto, err_bank, err_page, err_open}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][44:41], VEC[i][40:39], VEC[i][38:36], VEC[i][35:33],
            VEC[i][32:29], VEC[i][28:27], VEC[i][26:24], VEC[i][23:21], VEC[i][20:13]);
      step();
      check(rvalid == VEC[i][12], $sformatf("R6 vec%0d rvalid", i), int'(rvalid), int'(VEC[i][12]));
      check(rdata == VEC[i][11:4], $sformatf("R4 vec%0d rdata", i), int'(rdata), int'(VEC[i][11:4]));
      check({err_proto, err_bank, err_page, err_open} == VEC[i][3:0],
            $sformatf("R2/R3/R5/R7/R8 vec%0d errors", i),
            int'({err_proto, err_bank, err_page, err_open}), int'(VEC[i][3:0]));
    end

    // R9: page reads every cycle on bank 0 while port B writes bank 2 every cycle
    for (int k = 0; k < 16; k++) begin
      drive(4'h2, 2'd0, 3'd2, (k % 2 == 0) ? 3'd3 : 3'd4,
            4'h1, 2'd2, 3'd6, 3'(k % 8), 8'(100 + k));
      step();
      check(rvalid == 1'b1, "R9 rvalid every cycle", int'(rvalid), 1);
      check(rdata == ((k % 2 == 0) ? 8'd11 : 8'd33), "R9 read data", int'(rdata),
            (k % 2 == 0) ? 11 : 33);
    end
    for (int c = 0; c < 8; c++) begin
      drive(4'h2, 2'd2, 3'd6, 3'(c), 4'h0, 2'd0, 3'd0, 3'd0, 8'd0);
      step();
      check(rvalid && rdata == 8'(108 + c), "R9 concurrent writes stored", int'(rdata), 108 + c);
    end

    // R8: close then reopen bank 0 on a new row
    drive(4'h4, 2'd0, 3'd0, 3'd0, 4'h0, 2'd0, 3'd0, 3'd0, 8'd0);
    step();
    drive(4'h8, 2'd0, 3'd7, 3'd0, 4'h0, 2'd0, 3'd0, 3'd0, 8'd0);
    step();
    check(err_open == 1'b0, "R8 reopen after close", int'(err_open), 0);
    drive(4'h2, 2'd0, 3'd2, 3'd3, 4'h0, 2'd0, 3'd0, 3'd0, 8'd0);
    step();
    check(err_page == 1'b1 && rvalid == 1'b0, "R8 old row no longer open", int'(err_page), 1);

    // R10: reset closes every bank
    rst_n = 1'b0;
    drive(4'h0, 2'd0, 3'd0, 3'd0, 4'h0, 2'd0, 3'd0, 3'd0, 8'd0);
    step();
    check({rvalid, err_proto, err_bank, err_page, err_open} == '0, "R10 reset clears flags",
          int'({rvalid, err_proto, err_bank, err_page, err_open}), 0);
    rst_n = 1'b1;
    drive(4'h2, 2'd2, 3'd6, 3'd0, 4'h0, 2'd0, 3'd0, 3'd0, 8'd0);
    step();
    check(err_page == 1'b1 && rvalid == 1'b0, "R10 banks closed after reset", int'(err_page), 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule